// File: doc/BRIEF.md
# Watchdog Timer with Restart Key

A bus-attached watchdog peripheral. Software selects a countdown length as a power-of-two exponent and turns the timer on. From then on software must write a fixed restart key before the count runs out. If it does not, the block raises a reset request. In a second response mode it first raises an interrupt and only requests a reset if the next period also expires while that interrupt is still pending.

Two period codes exist. One sets the first countdown after the timer is turned on. The other sets every later countdown. Each code n gives 2^(BASE_EXP+n) clock cycles, and BASE_EXP defaults to 16. Access is through a plain 32-bit register bus with a 4-bit byte address, a write strobe and a read strobe. The register at 0x00 holds the enable (bit 0) and the response mode (bit 1). The register at 0x04 holds the normal period code in bits 3:0 and the first-period code in bits 7:4. The register at 0x08 is a read-only live count. The register at 0x0C takes the restart key.

Top module: `wdt_timer`

## Requirements
- R1: After reset, irq_o and rst_req_o are low, and reads of 0x00, 0x04 and 0x08 return zero.
- R2: The control register at 0x00 reads back as {mode in bit 1, enable in bit 0}, with all other bits zero. The range register at 0x04 reads back bits 7:0 as written. Writes to 0x08 change nothing. rdata_o is zero while rd_i is low.
- R3: A write to 0x00 that sets bit 0 while the timer is off loads the count with 2^(BASE_EXP+first code)-1. The count then falls by one each cycle, and the expiry acts on the 2^(BASE_EXP+code)-th clock edge after the load.
- R4: Every reload after the first (on expiry or on restart) uses the normal period code. A new normal code leaves the running count untouched and takes effect at the next reload.
- R5: A write to 0x0C whose bits 7:0 equal 0x76 reloads the count while the timer is on. Any other value does not reload it.
- R6: While the timer is off, the count holds its value, restart writes have no effect, no expiry occurs, and the pending interrupt is cleared.
- R7: In mode 0 (bit 1 = 0), an expiry drives rst_req_o high for exactly PULSE_LEN (default 8) cycles and reloads the count.
- R8: In mode 1, an expiry with no interrupt pending sets irq_o and leaves rst_req_o low. An expiry while irq_o is set drives rst_req_o for PULSE_LEN cycles, and irq_o stays set.
- R9: A valid restart write clears irq_o.
- R10: A valid restart write in the same cycle as an expiry wins: the count reloads and neither irq_o nor rst_req_o responds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 4 | Byte address of the register |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 32 | Read data, combinational, valid while rd_i is high |
| irq_o | output | 1 | Sticky early-warning interrupt (mode 1) |
| rst_req_o | output | 1 | System reset request pulse |

## Verification
A restart write and a count expiry can land on the same clock edge, and the block must let the restart win. The bench provokes this by turning the timer on with a 16-cycle period, waiting 15 cycles, and issuing the restart write so that it is captured on exactly the 16th edge. It judges the result at the ports. Both irq_o and rst_req_o must stay low, and the count must read back as the full reload value rather than a decremented one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 4;
  localparam logic [3:0] OFF_CTRL  = 4'h0;
  localparam logic [3:0] OFF_RANGE = 4'h4;
  localparam logic [3:0] OFF_COUNT = 4'h8;
  localparam logic [3:0] OFF_KICK  = 4'hC;
  localparam logic [7:0] KICK_KEY  = 8'h76;

  typedef enum logic {
    RESP_RESET     = 1'b0,
    RESP_IRQ_FIRST = 1'b1
  } resp_mode_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [3:0]        addr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] count_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              en_o,
  output resp_mode_e        mode_o,
  output logic [CODE_W-1:0] first_code_o,
  output logic [CODE_W-1:0] per_code_o,
  output logic              en_set_o,
  output logic              kick_o
);
  logic              en_q;
  resp_mode_e        mode_q;
  logic [2*CODE_W-1:0] range_q;
  logic              wr_ctrl, wr_range, wr_kick;

  assign wr_ctrl  = wr_i && (addr_i == OFF_CTRL);
  assign wr_range = wr_i && (addr_i == OFF_RANGE);
  assign wr_kick  = wr_i && (addr_i == OFF_KICK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= RESP_RESET;
      range_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata_i[0];
        mode_q <= resp_mode_e'(wdata_i[1]);
      end
      if (wr_range) range_q <= wdata_i[2*CODE_W-1:0];
    end
  end

  assign en_o         = en_q;
  assign mode_o       = mode_q;
  assign per_code_o   = range_q[CODE_W-1:0];
  assign first_code_o = range_q[2*CODE_W-1:CODE_W];
  // enable acts only on the off->on transition
  assign en_set_o     = wr_ctrl && wdata_i[0] && !en_q;
  assign kick_o       = wr_kick && (wdata_i[7:0] == KICK_KEY) && en_q;

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      unique case (addr_i)
        OFF_CTRL:  rdata_o = DATA_W'({mode_q, en_q});
        OFF_RANGE: rdata_o = DATA_W'(range_q);
        OFF_COUNT: rdata_o = count_i;
        default:   rdata_o = '0;
      endcase
    end
  end

  assert_bad_key_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_kick && wdata_i[7:0] != KICK_KEY) |-> !kick_o);
  assert_kick_needs_enable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !kick_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int BASE_EXP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              en_set_i,
  input  logic              kick_i,
  input  logic [CODE_W-1:0] first_code_i,
  input  logic [CODE_W-1:0] per_code_i,
  output logic [DATA_W-1:0] cnt_o,
  output logic              expire_o
);
  localparam int MAX_EXP = BASE_EXP + (1 << CODE_W) - 1;

  logic [DATA_W-1:0] cnt_q, first_max, per_max;

  function automatic logic [DATA_W-1:0] code_max(input logic [CODE_W-1:0] code);
    return (DATA_W'(1) << (BASE_EXP + int'(code))) - DATA_W'(1);
  endfunction

  assign first_max = code_max(first_code_i);
  assign per_max   = code_max(per_code_i);
  // restart in the expiry cycle wins
  assign expire_o  = en_i && (cnt_q == '0) && !kick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (en_set_i)                 cnt_q <= first_max;
    else if (en_i) begin
      if (kick_i || cnt_q == '0)       cnt_q <= per_max;
      else                             cnt_q <= cnt_q - DATA_W'(1);
    end
  end

  assign cnt_o = cnt_q;

  initial begin
    assert_exp_fits_R3: assert (MAX_EXP < DATA_W);
  end

  assert_first_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_set_i |=> cnt_q == $past(first_max));
  assert_reload_normal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_o |=> cnt_q == $past(per_max));
  assert_kick_reload_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> cnt_q == $past(per_max));
  assert_hold_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !en_set_i) |=> $stable(cnt_q));
endmodule

// File: rtl/wdt_resp.sv
module wdt_resp
  import wdt_pkg::*;
#(
  parameter int PULSE_LEN = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  resp_mode_e mode_i,
  input  logic       kick_i,
  input  logic       expire_i,
  output logic       irq_o,
  output logic       rst_req_o
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic          irq_q, fire_rst;
  logic [PW-1:0] pulse_q;

  assign fire_rst = expire_i && (mode_i == RESP_RESET || irq_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      pulse_q <= '0;
    end else begin
      if (!en_i || kick_i)                                  irq_q <= 1'b0;
      else if (expire_i && mode_i == RESP_IRQ_FIRST)        irq_q <= 1'b1;
      if (fire_rst)            pulse_q <= PW'(PULSE_LEN);
      else if (pulse_q != '0)  pulse_q <= pulse_q - PW'(1);
    end
  end

  assign irq_o     = irq_q;
  assign rst_req_o = (pulse_q != '0);

  assert_no_expiry_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !expire_i);
  assert_pulse_holds_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_req_o) |=> rst_req_o);
  assert_first_irq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire_i && mode_i == RESP_IRQ_FIRST) |=> irq_o);
  assert_kick_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> !irq_o);
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer
  import wdt_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int PULSE_LEN = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [3:0]  addr_i,
  input  logic        wr_i,
  input  logic [31:0] wdata_i,
  input  logic        rd_i,
  output logic [31:0] rdata_o,
  output logic        irq_o,
  output logic        rst_req_o
);
  logic              en, en_set, kick, expire;
  resp_mode_e        mode;
  logic [CODE_W-1:0] first_code, per_code;
  logic [DATA_W-1:0] cnt;

  wdt_regs u_regs (
    .clk_i, .rst_ni, .addr_i, .wr_i, .wdata_i, .rd_i,
    .count_i(cnt), .rdata_o, .en_o(en), .mode_o(mode),
    .first_code_o(first_code), .per_code_o(per_code),
    .en_set_o(en_set), .kick_o(kick)
  );

  wdt_counter #(.BASE_EXP(BASE_EXP)) u_counter (
    .clk_i, .rst_ni, .en_i(en), .en_set_i(en_set), .kick_i(kick),
    .first_code_i(first_code), .per_code_i(per_code),
    .cnt_o(cnt), .expire_o(expire)
  );

  wdt_resp #(.PULSE_LEN(PULSE_LEN)) u_resp (
    .clk_i, .rst_ni, .en_i(en), .mode_i(mode), .kick_i(kick),
    .expire_i(expire), .irq_o, .rst_req_o
  );
endmodule

// File: tb/wdt_timer_bench.sv
module wdt_timer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, rst_req;
  int          n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  wdt_timer #(.BASE_EXP(4), .PULSE_LEN(8)) u_wdt_timer (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rd_i(rd), .rdata_o(rdata), .irq_o(irq), .rst_req_o(rst_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // call just after a falling edge; captured at the next rising edge
  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 irq", 32'(irq), 0);
    check("R1 rst_req", 32'(rst_req), 0);
    bus_rd(4'h0, d); check("R1 ctrl", d, 0);
    bus_rd(4'h4, d); check("R1 range", d, 0);
    bus_rd(4'h8, d); check("R1 count", d, 0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    bus_wr(4'h4, 32'hFFFF_FFA5); bus_rd(4'h4, d); check("R2 range readback", d, 32'hA5);
    bus_wr(4'h0, 32'hFFFF_FFF2); bus_rd(4'h0, d); check("R2 ctrl readback", d, 32'h2);
    bus_wr(4'h8, 32'h1234);      bus_rd(4'h8, d); check("R2 count write ignored", d, 0);
    addr = 4'h4; #1 check("R2 rdata idle", rdata, 0);
    bus_wr(4'h0, 32'h0);
  endtask

  // mode 0, first code 1 (32 cycles), normal code 0 (16 cycles)
  task automatic t_mode0_and_kick;
    logic [31:0] d, c0;
    bus_wr(4'h4, 32'h10);
    bus_wr(4'h0, 32'h1);
    bus_rd(4'h8, d); check("R3 first load", d, 31);
    cyc(31); check("R3 no early expiry", 32'(rst_req), 0);
    cyc(1);  check("R7 reset on expiry", 32'(rst_req), 1);
    bus_rd(4'h8, d); check("R4 reload uses normal code", d, 15);
    check("R7 no irq in mode 0", 32'(irq), 0);
    cyc(7);  check("R7 pulse still high", 32'(rst_req), 1);
    cyc(1);  check("R7 pulse length 8", 32'(rst_req), 0);
    bus_rd(4'h8, c0);
    bus_wr(4'hC, 32'h75);
    bus_rd(4'h8, d); check("R5 wrong key ignored", d, c0 - 1);
    bus_wr(4'hC, 32'h76);
    bus_rd(4'h8, d); check("R5 key reloads", d, 15);
    bus_wr(4'h4, 32'h11);
    bus_rd(4'h8, d); check("R4 code change not immediate", d, 14);
    cyc(14); check("R4 still counting", 32'(rst_req), 0);
    cyc(1);
    bus_rd(4'h8, d); check("R4 new code at reload", d, 31);
    check("R7 second expiry", 32'(rst_req), 1);
  endtask

  task automatic t_disable;
    logic [31:0] c0, d;
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h8, c0);
    cyc(40);
    bus_rd(4'h8, d); check("R6 count holds", d, c0);
    check("R6 no reset when off", 32'(rst_req), 0);
    bus_wr(4'hC, 32'h76);
    bus_rd(4'h8, d); check("R6 restart ignored when off", d, c0);
  endtask

  task automatic t_mode1;
    logic [31:0] d;
    bus_wr(4'h4, 32'h00);
    bus_wr(4'h0, 32'h3);
    cyc(15); check("R8 no irq early", 32'(irq), 0);
    cyc(1);  check("R8 first expiry irq", 32'(irq), 1);
    check("R8 first expiry no reset", 32'(rst_req), 0);
    cyc(16); check("R8 second expiry reset", 32'(rst_req), 1);
    check("R8 irq kept", 32'(irq), 1);
    bus_wr(4'hC, 32'h76);
    check("R9 restart clears irq", 32'(irq), 0);
    bus_wr(4'h0, 32'h0);
    cyc(10);
  endtask

  task automatic t_mode1_kick;
    bus_wr(4'h0, 32'h3);
    cyc(16); check("R8 irq raised", 32'(irq), 1);
    bus_wr(4'hC, 32'h76);
    check("R9 irq cleared", 32'(irq), 0);
    cyc(15); check("R9 no irq before next expiry", 32'(irq), 0);
    cyc(1);  check("R8 fresh irq after clear", 32'(irq), 1);
    check("R8 fresh irq no reset", 32'(rst_req), 0);
    bus_wr(4'h0, 32'h0);
    cyc(4);
    check("R6 disable clears irq", 32'(irq), 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    bus_wr(4'h0, 32'h1);
    cyc(15);
    bus_wr(4'hC, 32'h76);   // captured on the expiry edge
    check("R10 no reset", 32'(rst_req), 0);
    check("R10 no irq", 32'(irq), 0);
    bus_rd(4'h8, d); check("R10 full reload", d, 15);
    bus_wr(4'h0, 32'h3);    // mode 1, still on
    cyc(14);
    bus_wr(4'hC, 32'h76);
    check("R10 mode 1 no irq", 32'(irq), 0);
    bus_wr(4'h0, 32'h0);
  endtask

  initial begin
    #200_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset;
    t_regs;
    t_mode0_and_kick;
    t_disable;
    t_mode1;
    t_mode1_kick;
    t_same_cycle;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule